// File: doc/BRIEF.md
# Strap-Latched Management Address and MII Isolate Control

This block fixes the management address of a port from five strap pins. Four receive-data pins and the collision pin carry the strap level while reset is held. On the first clock edge after reset is released, their levels are captured into the address field of a configuration register. From then on, those same pins act as ordinary outputs. Software can read the captured address through a simple register port and overwrite it later with any value from 0 to 31.

The block also owns the MII isolate state. Isolate is entered in one of two ways: a strapped address of zero, or software setting the isolate bit of the basic control register. A later management write of zero into the address field never isolates the port. While isolated, the transmit data and transmit enable inputs are forced to zero towards the core, and every MII output enable is held low so those pins float. The register port keeps working the whole time.

Top module: `mii_strap_isolate`

## Requirements
- R1: On the first rising clock edge after `rstN` goes high, the address field loads `{colPin, rxdPin[3:0]}`. Bit 0 comes from `rxdPin[0]`, bit 3 from `rxdPin[3]` and bit 4 from `colPin`. Every value 0 to 31 is accepted.
- R2: While reset is held, and until the strap sample is taken, `phyAddr` reads 5'b00001. This is the level the pin pulls give when the straps are left open.
- R3: A strapped value of 5'b00000 raises `isolate` in the same cycle that the address is captured.
- R4: A write to register 0x19 loads `mgmtWrData[4:0]` into the address field at the next edge. Writing 0 there never raises `isolate`.
- R5: A write to register 0x00 with data bit 10 set raises `isolate` at the next edge. A write with bit 10 clear drops `isolate`, even when isolate came from the strap.
- R6: While `isolate` is high, `txdGated` is 0 and `txEnGated` is 0. Otherwise they equal `txdIn` and `txEnIn`.
- R7: While `isolate` is high, all seven output enables are low (`oeTxClk`, `oeRxClk`, `oeRxDv`, `oeRxEr`, `oeRxd`, `oeCol`, `oeCrs`). Otherwise all seven are high once the sample is taken.
- R8: `oeRxd` and `oeCol` stay low from reset until the strap sample edge, so the shared pins never fight the straps.
- R9: `mgmtRdData` is combinational from `mgmtAddr`, and reads work while isolated:
  - address 0x19 returns the address field in bits [4:0], with the other bits 0;
  - address 0x00 returns `isolate` in bit 10, with the other bits 0;
  - every other address returns 0.
- R10: Changes on `rxdPin` or `colPin` after the sample edge do not alter `phyAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| rxdPin | input | 4 | Receive-data pin levels (strap bits 3:0 during reset) |
| colPin | input | 1 | Collision pin level (strap bit 4 during reset) |
| txdIn | input | 4 | Transmit data from the MII |
| txEnIn | input | 1 | Transmit enable from the MII |
| mgmtAddr | input | 5 | Management register number |
| mgmtWr | input | 1 | Write strobe, one cycle per write |
| mgmtWrData | input | 16 | Write data |
| mgmtRdData | output | 16 | Read data for `mgmtAddr` |
| phyAddr | output | 5 | Current management address |
| isolate | output | 1 | MII isolate state |
| txdGated | output | 4 | Transmit data towards the core |
| txEnGated | output | 1 | Transmit enable towards the core |
| oeTxClk | output | 1 | Output enable, transmit clock |
| oeRxClk | output | 1 | Output enable, receive clock |
| oeRxDv | output | 1 | Output enable, receive data valid |
| oeRxEr | output | 1 | Output enable, receive error |
| oeRxd | output | 1 | Output enable, receive data (shared strap pins) |
| oeCol | output | 1 | Output enable, collision (shared strap pin) |
| oeCrs | output | 1 | Output enable, carrier sense |

## Verification
The bench releases reset at a falling edge. Just before the sample edge it checks that the shared pin enables are still low and the address still reads 1. A design that samples one edge late, or enables RXD/COL early, fails there. It straps zero, then writes zero into the address field of a running port, so a design that derives isolate from the live address gets caught. It also clears the control bit after a strap-induced isolate, which catches a design whose strap isolate cannot be left. Finally it toggles the shared pins after the sample, to catch an address register that keeps tracking the pins.

// File: rtl/mii_strap_pkg.sv
package mii_strap_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int TXD_W  = 4;
  localparam int ISO_BIT = 10;
  localparam logic [ADDR_W-1:0] REG_CTL = 5'h00;
  localparam logic [ADDR_W-1:0] REG_CFG = 5'h19;
  localparam logic [ADDR_W-1:0] OPEN_STRAP = 5'b00001;

  typedef struct packed {
    logic doSample;
    logic wrAddr;
    logic wrCtl;
  } strobe_t;
endpackage

// File: rtl/mii_strap_ctrl.sv
module mii_strap_ctrl
  import mii_strap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              mgmtWr,
  input  logic [ADDR_W-1:0] mgmtAddr,
  input  logic              isolate,
  output strobe_t           stb,
  output logic              sampled,
  output logic              oeShared,
  output logic              oeOther
);
  logic sampledQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampledQ <= 1'b0;
    else       sampledQ <= 1'b1;
  end

  always_comb begin
    stb          = '0;
    stb.doSample = !sampledQ;
    stb.wrAddr   = sampledQ && mgmtWr && (mgmtAddr == REG_CFG);
    stb.wrCtl    = sampledQ && mgmtWr && (mgmtAddr == REG_CTL);
  end

  assign sampled  = sampledQ;
  assign oeShared = sampledQ && !isolate;
  assign oeOther  = !isolate;
endmodule

// File: rtl/mii_strap_dp.sv
module mii_strap_dp
  import mii_strap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEF_ADDR = OPEN_STRAP
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] strapPins,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [TXD_W-1:0]  txdIn,
  input  logic              txEnIn,
  output logic [ADDR_W-1:0] phyAddr,
  output logic              isolate,
  output logic [DATA_W-1:0] rdData,
  output logic [TXD_W-1:0]  txdOut,
  output logic              txEnOut
);
  logic [ADDR_W-1:0] addrQ;
  logic strapIsoQ;
  logic ctlIsoQ;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= DEF_ADDR;
    end else if (stb.doSample) begin
      addrQ <= strapPins;
    end else if (stb.wrAddr) begin
      addrQ <= wrData[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapIsoQ <= 1'b0;
    end else if (stb.doSample) begin
      strapIsoQ <= (strapPins == '0);
    end else if (stb.wrCtl && !wrData[ISO_BIT]) begin
      strapIsoQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ctlIsoQ <= 1'b0;
    else if (stb.wrCtl) ctlIsoQ <= wrData[ISO_BIT];
  end

  assign isolate = strapIsoQ || ctlIsoQ;
  assign phyAddr = addrQ;

  always_comb begin
    rdData = '0;
    case (rdAddr)
      REG_CFG: rdData[ADDR_W-1:0] = addrQ;
      REG_CTL: rdData[ISO_BIT]    = isolate;
      default: rdData = '0;
    endcase
  end

  for (genvar i = 0; i < TXD_W; i++) begin : g_txGate
    assign txdOut[i] = txdIn[i] && !isolate;
  end
  assign txEnOut = txEnIn && !isolate;
endmodule

// File: rtl/mii_strap_isolate.sv
module mii_strap_isolate
  import mii_strap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        rxdPin,
  input  logic              colPin,
  input  logic [TXD_W-1:0]  txdIn,
  input  logic              txEnIn,
  input  logic [ADDR_W-1:0] mgmtAddr,
  input  logic              mgmtWr,
  input  logic [DATA_W-1:0] mgmtWrData,
  output logic [DATA_W-1:0] mgmtRdData,
  output logic [ADDR_W-1:0] phyAddr,
  output logic              isolate,
  output logic [TXD_W-1:0]  txdGated,
  output logic              txEnGated,
  output logic              oeTxClk,
  output logic              oeRxClk,
  output logic              oeRxDv,
  output logic              oeRxEr,
  output logic              oeRxd,
  output logic              oeCol,
  output logic              oeCrs
);
  strobe_t stb;
  logic sampled;
  logic oeShared;
  logic oeOther;

  mii_strap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mgmtWr   (mgmtWr),
    .mgmtAddr (mgmtAddr),
    .isolate  (isolate),
    .stb      (stb),
    .sampled  (sampled),
    .oeShared (oeShared),
    .oeOther  (oeOther)
  );

  mii_strap_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .strapPins ({colPin, rxdPin}),
    .wrData    (mgmtWrData),
    .rdAddr    (mgmtAddr),
    .txdIn     (txdIn),
    .txEnIn    (txEnIn),
    .phyAddr   (phyAddr),
    .isolate   (isolate),
    .rdData    (mgmtRdData),
    .txdOut    (txdGated),
    .txEnOut   (txEnGated)
  );

  assign oeRxd   = oeShared;
  assign oeCol   = oeShared;
  assign oeTxClk = oeOther;
  assign oeRxClk = oeOther;
  assign oeRxDv  = oeOther;
  assign oeRxEr  = oeOther;
  assign oeCrs   = oeOther;
endmodule

// File: rtl/mii_strap_chk.sv
module mii_strap_chk
  import mii_strap_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sampled,
  input logic [3:0]        rxdPin,
  input logic              colPin,
  input logic [ADDR_W-1:0] mgmtAddr,
  input logic              mgmtWr,
  input logic [DATA_W-1:0] mgmtWrData,
  input logic [ADDR_W-1:0] phyAddr,
  input logic              isolate,
  input logic [TXD_W-1:0]  txdGated,
  input logic              txEnGated,
  input logic              oeTxClk,
  input logic              oeRxClk,
  input logic              oeRxDv,
  input logic              oeRxEr,
  input logic              oeRxd,
  input logic              oeCol,
  input logic              oeCrs
);
  AST_STRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampled) |-> phyAddr == $past({colPin, rxdPin})); // R1
  AST_STRAP_ZERO_ISO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampled) |-> isolate == ($past({colPin, rxdPin}) == '0)); // R3
  AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (sampled && mgmtWr && mgmtAddr == REG_CFG) |=> phyAddr == $past(mgmtWrData[ADDR_W-1:0])); // R4
  AST_ZERO_WR_NO_ISO: assert property (@(posedge clk) disable iff (!rstN)
    (sampled && mgmtWr && mgmtAddr == REG_CFG && !isolate) |=> !isolate); // R4
  AST_CTL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (sampled && mgmtWr && mgmtAddr == REG_CTL && !mgmtWrData[ISO_BIT]) |=> !isolate); // R5
  AST_CTL_SET: assert property (@(posedge clk) disable iff (!rstN)
    (sampled && mgmtWr && mgmtAddr == REG_CTL && mgmtWrData[ISO_BIT]) |=> isolate); // R5
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rstN)
    isolate |-> (txdGated == '0 && !txEnGated)); // R6
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    isolate |-> !(oeTxClk || oeRxClk || oeRxDv || oeRxEr || oeRxd || oeCol || oeCrs)); // R7
  AST_SHARED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampled |-> (!oeRxd && !oeCol)); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (sampled && !(mgmtWr && mgmtAddr == REG_CFG)) |=> $stable(phyAddr)); // R10
endmodule

bind mii_strap_isolate mii_strap_chk u_chk (.*);

// File: tb/mii_strap_isolate_bench.sv
`timescale 1ns/1ps
module mii_strap_isolate_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] rxdPin = 4'h0;
  logic colPin = 1'b0;
  logic [3:0] txdIn = 4'h0;
  logic txEnIn = 1'b0;
  logic [4:0] mgmtAddr = 5'h0;
  logic mgmtWr = 1'b0;
  logic [15:0] mgmtWrData = 16'h0;
  logic [15:0] mgmtRdData;
  logic [4:0] phyAddr;
  logic isolate;
  logic [3:0] txdGated;
  logic txEnGated;
  logic oeTxClk, oeRxClk, oeRxDv, oeRxEr, oeRxd, oeCol, oeCrs;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mii_strap_isolate u_mii_strap_isolate (
    .clk(clk), .rstN(rstN), .rxdPin(rxdPin), .colPin(colPin),
    .txdIn(txdIn), .txEnIn(txEnIn), .mgmtAddr(mgmtAddr), .mgmtWr(mgmtWr),
    .mgmtWrData(mgmtWrData), .mgmtRdData(mgmtRdData), .phyAddr(phyAddr),
    .isolate(isolate), .txdGated(txdGated), .txEnGated(txEnGated),
    .oeTxClk(oeTxClk), .oeRxClk(oeRxClk), .oeRxDv(oeRxDv), .oeRxEr(oeRxEr),
    .oeRxd(oeRxd), .oeCol(oeCol), .oeCrs(oeCrs)
  );

  function automatic logic [6:0] allOe();
    return {oeTxClk, oeRxClk, oeRxDv, oeRxEr, oeRxd, oeCol, oeCrs};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic readReg(input logic [4:0] a, output logic [15:0] d);
    mgmtAddr = a;
    #1;
    d = mgmtRdData;
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    mgmtAddr = a; mgmtWrData = d; mgmtWr = 1'b1;
    @(negedge clk);
    mgmtWr = 1'b0;
  endtask

  // Reset with a strap value, check the pre-sample state, then the capture.
  task automatic strapAndRelease(input logic [4:0] val);
    @(negedge clk);
    rstN = 1'b0;
    {colPin, rxdPin} = val;
    repeat (2) @(negedge clk);
    check(phyAddr == 5'b00001, "R2 open-strap address in reset", 16'(phyAddr), 16'h1);
    rstN = 1'b1;
    #1;
    check(oeRxd == 1'b0 && oeCol == 1'b0, "R8 shared OE low before sample", 16'({oeRxd, oeCol}), 16'h0);
    check(phyAddr == 5'b00001, "R2 address before sample edge", 16'(phyAddr), 16'h1);
    @(negedge clk);
    check(phyAddr == val, "R1 strap capture", 16'(phyAddr), 16'(val));
    check(isolate == (val == 5'd0), "R3 isolate from strap", 16'(isolate), 16'(val == 5'd0));
  endtask

  task automatic testNormalStrap();
    logic [15:0] d;
    strapAndRelease(5'b00011);
    check(allOe() == 7'h7F, "R7 all OE high when not isolated", 16'(allOe()), 16'h7F);
    readReg(5'h19, d);
    check(d == 16'h0003, "R9 read address register", d, 16'h0003);
    readReg(5'h00, d);
    check(d == 16'h0000, "R9 read control register", d, 16'h0000);
    readReg(5'h07, d);
    check(d == 16'h0000, "R9 unmapped register reads zero", d, 16'h0000);
  endtask

  task automatic testPinsAfterSample();
    @(negedge clk);
    rxdPin = 4'hA; colPin = 1'b1;
    repeat (3) @(negedge clk);
    check(phyAddr == 5'b00011, "R10 pins ignored after sample", 16'(phyAddr), 16'h3);
    rxdPin = 4'h0; colPin = 1'b0;
  endtask

  task automatic testPassThrough();
    txdIn = 4'h9; txEnIn = 1'b1;
    #1;
    check(txdGated == 4'h9 && txEnGated == 1'b1, "R6 transmit pass-through", 16'({txEnGated, txdGated}), 16'h19);
  endtask

  task automatic testWriteZeroAddr();
    logic [15:0] d;
    writeReg(5'h19, 16'hFFE0);
    check(phyAddr == 5'd0, "R4 address write of zero", 16'(phyAddr), 16'h0);
    check(isolate == 1'b0, "R4 zero write does not isolate", 16'(isolate), 16'h0);
    writeReg(5'h19, 16'h001F);
    readReg(5'h19, d);
    check(d == 16'h001F, "R4 address write of 31", d, 16'h001F);
  endtask

  task automatic testCtlIsolate();
    logic [15:0] d;
    writeReg(5'h00, 16'h0400);
    check(isolate == 1'b1, "R5 control bit sets isolate", 16'(isolate), 16'h1);
    #1;
    check(txdGated == 4'h0 && txEnGated == 1'b0, "R6 transmit gated in isolate", 16'({txEnGated, txdGated}), 16'h0);
    check(allOe() == 7'h00, "R7 OEs low in isolate", 16'(allOe()), 16'h0);
    readReg(5'h00, d);
    check(d == 16'h0400, "R9 control read shows isolate", d, 16'h0400);
    writeReg(5'h00, 16'h0000);
    check(isolate == 1'b0, "R5 control clear leaves isolate", 16'(isolate), 16'h0);
  endtask

  task automatic testStrapZero();
    logic [15:0] d;
    strapAndRelease(5'b00000);
    txdIn = 4'hF; txEnIn = 1'b1;
    #1;
    check(txdGated == 4'h0 && txEnGated == 1'b0, "R6 gated after strap isolate", 16'({txEnGated, txdGated}), 16'h0);
    check(allOe() == 7'h00, "R7 OEs low after strap isolate", 16'(allOe()), 16'h0);
    writeReg(5'h19, 16'h0005);
    readReg(5'h19, d);
    check(d == 16'h0005, "R9 management works while isolated", d, 16'h0005);
    check(isolate == 1'b1, "R3 isolate kept after address write", 16'(isolate), 16'h1);
    writeReg(5'h00, 16'h0000);
    check(isolate == 1'b0, "R5 clear drops strap isolate", 16'(isolate), 16'h0);
    check(allOe() == 7'h7F, "R7 OEs back after clear", 16'(allOe()), 16'h7F);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    testNormalStrap();
    testPinsAfterSample();
    testPassThrough();
    testWriteZeroAddr();
    testCtlIsolate();
    testStrapZero();
    strapAndRelease(5'b11111);
    strapAndRelease(5'b10100);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule